// File: doc/BRIEF.md
# Streamed DAC Write Controller

This block replays bytes from a sample data bank into a register of a target sound chip at a programmed rate, running alongside the command stream. A small set of streams each holds a target binding (chip type, port and register), a data-bank selection with a stride and a base offset, a write rate in Hz and a playback length. On every active sample tick each running stream adds its rate to a phase accumulator. When the accumulator wraps, the stream schedules one read of the data bank. The byte that comes back is issued as a register write tagged with the stream's binding.

A single command port configures the streams, defines a small table of blocks, and starts and stops playback. A length can be a count of writes, a duration in milliseconds, or a run to the end of the defined data. Playback can go forwards or backwards, and it can restart by itself when it finishes. The data bank sits outside the block and is reached through a read port with one cycle of latency.

Top module: `dac_stream_ctrl`

## Requirements
- R1: After reset, no stream runs, and rd_en and wr_valid stay low until a stream is started.
- R2: Command op 0 (setup) binds the stream named by cmd_id to chip type cmd_a[7:0], port cmd_a[15:8] and register cmd_a[23:16]. Every write from that stream carries these values unchanged on wr_chip, wr_port and wr_reg, including bit 7 of the chip type, which selects the second chip instance.
- R3: Command op 2 sets a 32-bit rate from cmd_a. On each cycle with tick high, a running stream adds the rate to its accumulator, which starts at 0. A write is scheduled each time the sum reaches TICK_HZ, and TICK_HZ is then subtracted from it. A rate at or above TICK_HZ yields exactly one write per tick.
- R4: Command op 1 sets the bank (cmd_a[7:0]), the step (cmd_a[15:8]) and the base (cmd_a[23:16]). A start with offset O begins at address O+base, and each write advances the address by the step.
- R5: Command op 3 (start) takes the offset in cmd_a, the length in cmd_b and the mode in cmd_c. An offset of 0xFFFFFFFF keeps the current address, with no base added. Mode bits [1:0] = 0 only change the address and do not start playback.
- R6: Mode 1 issues exactly cmd_b writes and then stops.
- R7: Mode 2 issues floor(rate × cmd_b / 1000) writes, where cmd_b is a length in milliseconds.
- R8: Mode 3 plays forwards until the address reaches the bank end, which is the largest start+length over all blocks defined so far. In reverse, it plays down to and including address 0.
- R9: Mode bit 4 selects reverse playback, in which the address falls by the step after each write.
- R10: Mode bit 7 selects looping. When the length runs out, the stream returns to its start address and full length. The tick slot in which the end is detected produces no write.
- R11: Command op 5 stops the named stream. cmd_id 0xFF stops every stream. Any other cmd_id at or above NSTREAM has no effect.
- R12: Command op 6 stores block cmd_id with start cmd_a and length cmd_b in bytes. Op 4 (fast start) plays block cmd_a from start+base for floor(length/step) writes. Flag bit 0 of cmd_c selects loop. Flag bit 4 selects reverse, which begins at start+base+length−step.
- R13: Each write is preceded by a read on rd_en/rd_addr, with the stream's bank on rd_bank. wr_data is the byte returned one cycle after rd_en. When several streams are due in the same cycle, lower stream indices are served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle sample-rate pulse |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 setup, 1 data, 2 rate, 3 start, 4 fast start, 5 stop, 6 block) |
| cmd_id | input | 8 | Stream ID, or block index for op 6 |
| cmd_a | input | 32 | First argument |
| cmd_b | input | 32 | Second argument |
| cmd_c | input | 8 | Mode or flag byte |
| rd_en | output | 1 | Data-bank read request |
| rd_bank | output | 8 | Bank ID of the read |
| rd_addr | output | AW | Byte address of the read |
| rd_data | input | 8 | Byte returned one cycle after rd_en |
| wr_valid | output | 1 | Register write strobe |
| wr_chip | output | 8 | Target chip type |
| wr_port | output | 8 | Target port |
| wr_reg | output | 8 | Target register |
| wr_data | output | 8 | Byte to write |

## Verification
The bench keeps the default four streams, four blocks, 16-bit addresses and 40-bit length counter, but sets TICK_HZ to 8. With that setting, rates of 4, 8 and 20 give a write every second tick, every tick, and the capped one-per-tick case, all within a few ticks. Millisecond lengths such as 375 and 374 at rate 8 land on either side of a whole write, which exposes the rounding. Four streams leave stream IDs 4–254 to show that stops addressed to a missing stream are ignored.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    OP_SETUP = 3'd0,
    OP_DATA  = 3'd1,
    OP_RATE  = 3'd2,
    OP_START = 3'd3,
    OP_FAST  = 3'd4,
    OP_STOP  = 3'd5,
    OP_BLOCK = 3'd6,
    OP_NONE  = 3'd7
  } op_e;

  typedef struct packed {
    logic [7:0] chip;
    logic [7:0] port;
    logic [7:0] regsel;
  } wmeta_t;

  localparam logic [7:0] ID_ALL   = 8'hFF;
  localparam int         MS_UNITS = 1000;

endpackage

// File: rtl/dsc_phase.sv
module dsc_phase #(
  parameter int RATE_W  = 32,
  parameter int TICK_HZ = 44100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              ovf
);
  localparam int ACC_W = RATE_W + 1;
  localparam logic [ACC_W-1:0] LIM = ACC_W'(TICK_HZ);

  logic [ACC_W-1:0] acc, sum, rem;

  always_comb begin
    sum = acc + {1'b0, rate};
    rem = sum - LIM;
    ovf = en && (sum >= LIM);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (en) begin
      if (sum >= LIM) acc <= (rem >= LIM) ? LIM - 1'b1 : rem;
      else            acc <= sum;
    end
  end
endmodule

// File: rtl/dsc_stream.sv
module dsc_stream import dsc_pkg::*; #(
  parameter int AW      = 16,
  parameter int CNT_W   = 40,
  parameter int TICK_HZ = 44100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cmd_hit,
  input  logic          stop_all,
  input  logic [2:0]    cmd_op,
  input  logic [31:0]   cmd_a,
  input  logic [31:0]   cmd_b,
  input  logic [7:0]    cmd_c,
  input  logic [AW-1:0] fs_start,
  input  logic [AW-1:0] fs_len,
  input  logic [AW-1:0] bank_end,
  input  logic          grant,
  output logic          pend,
  output logic [AW-1:0] paddr,
  output wmeta_t        meta,
  output logic [7:0]    bank,
  output logic          running
);
  localparam int DEC_W = $clog2(MS_UNITS + 1);

  logic [7:0]       step, base;
  logic [31:0]      rate;
  logic [AW-1:0]    pos, start_pos;
  logic [CNT_W-1:0] budget, init_budget;
  logic [DEC_W-1:0] dec;
  logic [1:0]       mode;
  logic             rev, loop_en, wrap;

  op_e              op;
  logic [AW-1:0]    start_pos_c, fast_pos_c, next_pos;
  logic [63:0]      prod;
  logic [CNT_W-1:0] len_c;
  logic [DEC_W-1:0] dec_c;
  logic             restart, ovf, done;

  always_comb begin
    op          = op_e'(cmd_op);
    start_pos_c = (cmd_a == 32'hFFFF_FFFF) ? pos : cmd_a[AW-1:0] + AW'(base);
    fast_pos_c  = fs_start + AW'(base) + (cmd_c[4] ? fs_len - AW'(step) : '0);
    prod        = {32'b0, rate} * {32'b0, cmd_b};
    unique case (cmd_c[1:0])
      2'd1:    begin len_c = CNT_W'(cmd_b); dec_c = DEC_W'(1); end
      2'd2:    begin len_c = CNT_W'(prod);  dec_c = DEC_W'(MS_UNITS); end
      default: begin len_c = '0;            dec_c = '0; end
    endcase
    next_pos = rev ? pos - AW'(step) : pos + AW'(step);
    if (mode == 2'd3) done = rev ? wrap : (pos >= bank_end);
    else              done = budget < CNT_W'(dec);
    restart  = cmd_hit && ((op == OP_START && cmd_c[1:0] != 2'd0) || op == OP_FAST);
  end

  dsc_phase #(.RATE_W(32), .TICK_HZ(TICK_HZ)) u_phase (
    .clk(clk), .rst(rst), .clr(restart || stop_all), .en(tick && running),
    .rate(rate), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0; bank <= '0; step <= '0; base <= '0; rate <= '0;
      pos <= '0; start_pos <= '0; budget <= '0; init_budget <= '0; dec <= '0;
      mode <= '0; rev <= 1'b0; loop_en <= 1'b0; wrap <= 1'b0;
      running <= 1'b0; pend <= 1'b0; paddr <= '0;
    end else begin
      if (grant) pend <= 1'b0;
      if (stop_all) begin
        running <= 1'b0;
        pend    <= 1'b0;
      end else if (cmd_hit) begin
        unique case (op)
          OP_SETUP: meta <= '{chip: cmd_a[7:0], port: cmd_a[15:8], regsel: cmd_a[23:16]};
          OP_DATA: begin
            bank <= cmd_a[7:0];
            step <= cmd_a[15:8];
            base <= cmd_a[23:16];
          end
          OP_RATE: rate <= cmd_a;
          OP_START: begin
            pos <= start_pos_c;
            if (cmd_c[1:0] != 2'd0) begin
              mode <= cmd_c[1:0]; rev <= cmd_c[4]; loop_en <= cmd_c[7];
              start_pos <= start_pos_c; budget <= len_c; init_budget <= len_c;
              dec <= dec_c; wrap <= 1'b0; running <= 1'b1; pend <= 1'b0;
            end
          end
          OP_FAST: begin
            pos <= fast_pos_c; start_pos <= fast_pos_c;
            mode <= 2'd1; rev <= cmd_c[4]; loop_en <= cmd_c[0];
            budget <= CNT_W'(fs_len); init_budget <= CNT_W'(fs_len);
            dec <= DEC_W'(step); wrap <= 1'b0; running <= 1'b1; pend <= 1'b0;
          end
          OP_STOP: begin
            running <= 1'b0;
            pend    <= 1'b0;
          end
          default: ;
        endcase
      end else if (ovf) begin
        if (done) begin
          if (loop_en) begin
            pos <= start_pos; budget <= init_budget; wrap <= 1'b0;
          end else begin
            running <= 1'b0;
          end
        end else if (!pend || grant) begin
          pend   <= 1'b1;
          paddr  <= pos;
          pos    <= next_pos;
          budget <= budget - CNT_W'(dec);
          wrap   <= rev && (pos < AW'(step));
        end
      end
    end
  end
endmodule

// File: rtl/dsc_arb.sv
module dsc_arb import dsc_pkg::*; #(
  parameter int N  = 4,
  parameter int AW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          pend,
  input  logic [N-1:0][AW-1:0]  paddr,
  input  wmeta_t [N-1:0]        meta,
  input  logic [N-1:0][7:0]     bank,
  input  logic [7:0]            rd_data,
  output logic [N-1:0]          grant,
  output logic                  rd_en,
  output logic [7:0]            rd_bank,
  output logic [AW-1:0]         rd_addr,
  output logic                  wr_valid,
  output wmeta_t                wr_meta,
  output logic [7:0]            wr_data
);
  logic          found;
  logic [AW-1:0] sel_addr;
  logic [7:0]    sel_bank;
  wmeta_t        sel_meta, m1, m2;
  logic          v1, v2;

  always_comb begin
    grant    = '0;
    found    = 1'b0;
    sel_addr = '0;
    sel_bank = '0;
    sel_meta = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && !found) begin
        found    = 1'b1;
        grant[i] = 1'b1;
        sel_addr = paddr[i];
        sel_bank = bank[i];
        sel_meta = meta[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en <= 1'b0; rd_bank <= '0; rd_addr <= '0;
      v1 <= 1'b0; v2 <= 1'b0; m1 <= '0; m2 <= '0;
      wr_valid <= 1'b0; wr_meta <= '0; wr_data <= '0;
    end else begin
      rd_en <= found;
      if (found) begin
        rd_addr <= sel_addr;
        rd_bank <= sel_bank;
      end
      v1 <= found;    m1 <= sel_meta;
      v2 <= v1;       m2 <= m1;
      wr_valid <= v2;
      if (v2) begin
        wr_meta <= m2;
        wr_data <= rd_data;
      end
    end
  end
endmodule

// File: rtl/dac_stream_ctrl.sv
module dac_stream_ctrl import dsc_pkg::*; #(
  parameter int NSTREAM = 4,
  parameter int NBLOCK  = 4,
  parameter int AW      = 16,
  parameter int CNT_W   = 40,
  parameter int TICK_HZ = 44100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [7:0]    cmd_id,
  input  logic [31:0]   cmd_a,
  input  logic [31:0]   cmd_b,
  input  logic [7:0]    cmd_c,
  output logic          rd_en,
  output logic [7:0]    rd_bank,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_valid,
  output logic [7:0]    wr_chip,
  output logic [7:0]    wr_port,
  output logic [7:0]    wr_reg,
  output logic [7:0]    wr_data
);
  localparam int BLK_W = (NBLOCK > 1) ? $clog2(NBLOCK) : 1;

  logic [AW-1:0] blk_start [NBLOCK];
  logic [AW-1:0] blk_len   [NBLOCK];
  logic [AW-1:0] bank_end, blk_end_c, fs_start, fs_len;
  logic          stop_all;

  logic [NSTREAM-1:0]          pend_w, grant_w, run_w;
  logic [NSTREAM-1:0][AW-1:0]  paddr_w;
  logic [NSTREAM-1:0][7:0]     bank_w;
  wmeta_t [NSTREAM-1:0]        meta_w;
  wmeta_t                      wr_meta;

  always_comb begin
    blk_end_c = cmd_a[AW-1:0] + cmd_b[AW-1:0];
    fs_start  = blk_start[cmd_a[BLK_W-1:0]];
    fs_len    = blk_len[cmd_a[BLK_W-1:0]];
    stop_all  = cmd_valid && (op_e'(cmd_op) == OP_STOP) && (cmd_id == ID_ALL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBLOCK; i++) begin
        blk_start[i] <= '0;
        blk_len[i]   <= '0;
      end
      bank_end <= '0;
    end else if (cmd_valid && op_e'(cmd_op) == OP_BLOCK && 32'(cmd_id) < NBLOCK) begin
      blk_start[cmd_id[BLK_W-1:0]] <= cmd_a[AW-1:0];
      blk_len[cmd_id[BLK_W-1:0]]   <= cmd_b[AW-1:0];
      if (blk_end_c > bank_end) bank_end <= blk_end_c;
    end
  end

  for (genvar g = 0; g < NSTREAM; g++) begin : g_strm
    dsc_stream #(.AW(AW), .CNT_W(CNT_W), .TICK_HZ(TICK_HZ)) u_strm (
      .clk(clk), .rst(rst), .tick(tick),
      .cmd_hit(cmd_valid && cmd_id == 8'(g)), .stop_all(stop_all),
      .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_c(cmd_c),
      .fs_start(fs_start), .fs_len(fs_len), .bank_end(bank_end),
      .grant(grant_w[g]), .pend(pend_w[g]), .paddr(paddr_w[g]),
      .meta(meta_w[g]), .bank(bank_w[g]), .running(run_w[g])
    );
  end

  dsc_arb #(.N(NSTREAM), .AW(AW)) u_arb (
    .clk(clk), .rst(rst), .pend(pend_w), .paddr(paddr_w), .meta(meta_w),
    .bank(bank_w), .rd_data(rd_data), .grant(grant_w), .rd_en(rd_en),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .wr_valid(wr_valid),
    .wr_meta(wr_meta), .wr_data(wr_data)
  );

  assign wr_chip = wr_meta.chip;
  assign wr_port = wr_meta.port;
  assign wr_reg  = wr_meta.regsel;
endmodule

// File: rtl/dsc_chk.sv
module dsc_chk import dsc_pkg::*; #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic [7:0]   cmd_id,
  input logic         rd_en,
  input logic         wr_valid,
  input logic [N-1:0] grant,
  input logic [N-1:0] pend,
  input logic [N-1:0] running
);
  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    rst |=> (!rd_en && !wr_valid && running == '0));

  // R13
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R13
  grant_only_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~pend) == '0);

  // R13
  read_follows_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (|grant) |=> rd_en);

  // R13
  write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(rd_en, 2));

  // R11
  stop_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op_e'(cmd_op) == OP_STOP && cmd_id == ID_ALL) |=> (running == '0 && pend == '0));
endmodule

bind dac_stream_ctrl dsc_chk #(.N(NSTREAM)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
  .rd_en(rd_en), .wr_valid(wr_valid), .grant(grant_w), .pend(pend_w), .running(run_w)
);

// File: tb/tb_dac_stream_ctrl.sv
module tb_dac_stream_ctrl;
  localparam int AW = 16;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_id = '0, cmd_c = '0;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic rd_en, wr_valid;
  logic [7:0] rd_bank, rd_data, wr_chip, wr_port, wr_reg, wr_data;
  logic [AW-1:0] rd_addr;

  int nchk = 0, nbad = 0, nlog = 0;
  logic [7:0] ld [64];
  logic [7:0] lc [64];
  logic [7:0] lp [64];
  logic [7:0] lr [64];
  logic [7:0] last_bank = '0;

  always #4 clk = ~clk;

  dac_stream_ctrl #(.TICK_HZ(8)) dut (
    .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_id(cmd_id), .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_c(cmd_c),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_chip(wr_chip), .wr_port(wr_port), .wr_reg(wr_reg),
    .wr_data(wr_data)
  );

  function automatic logic [7:0] memf(input logic [7:0] b, input logic [15:0] a);
    return a[7:0] ^ {a[11:8], 4'h0} ^ {b[3:0], b[3:0]};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= memf(rd_bank, rd_addr);

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid && nlog < 64) begin
        ld[nlog] = wr_data; lc[nlog] = wr_chip; lp[nlog] = wr_port; lr[nlog] = wr_reg;
        nlog++;
      end
      if (rd_en) last_bank = rd_bank;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_at(input string tag, input int i, input logic [7:0] b, input int addr);
    chk(tag, 32'(ld[i]), 32'(memf(b, 16'(addr))));
  endtask

  task automatic chk_seq(input string tag, input logic [7:0] b, input int n, input int a0, input int stp);
    chk({tag, " count"}, 32'(nlog), 32'(n));
    for (int k = 0; k < n && k < nlog; k++) chk_at(tag, k, b, a0 + k * stp);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] id, input logic [31:0] a,
                     input logic [31:0] b, input logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_a = a; cmd_b = b; cmd_c = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 rd_en", 32'(rd_en), 0);
    chk("R1 wr_valid", 32'(wr_valid), 0);
    nlog = 0;
    ticks(2);
    chk("R1 no writes", 32'(nlog), 0);
  endtask

  task automatic t_basic();
    cmd(3'd0, 8'd0, 32'h002A_0182, 0, 0);
    cmd(3'd1, 8'd0, 32'h0001_0203, 0, 0);
    cmd(3'd2, 8'd0, 32'd4, 0, 0);
    nlog = 0;
    cmd(3'd3, 8'd0, 32'd16, 32'd3, 8'h01);
    ticks(1);
    chk("R3 no write first tick", 32'(nlog), 0);
    ticks(1);
    chk("R3 write second tick", 32'(nlog), 1);
    ticks(8);
    chk_seq("R4 R6 stride", 8'd3, 3, 17, 2);
    chk("R2 chip", 32'(lc[0]), 32'h82);
    chk("R2 port", 32'(lp[1]), 32'h01);
    chk("R2 reg", 32'(lr[2]), 32'h2A);
    chk("R13 bank", 32'(last_bank), 32'd3);
    cmd(3'd2, 8'd0, 32'd20, 0, 0);
    nlog = 0;
    cmd(3'd3, 8'd0, 32'd0, 32'd4, 8'h01);
    ticks(4);
    chk_seq("R3 capped rate", 8'd3, 4, 1, 2);
  endtask

  task automatic t_keep();
    nlog = 0;
    cmd(3'd3, 8'd0, 32'hFFFF_FFFF, 32'd5, 8'h00);
    ticks(3);
    chk("R5 mode0 no play", 32'(nlog), 0);
    cmd(3'd3, 8'd0, 32'hFFFF_FFFF, 32'd2, 8'h01);
    ticks(3);
    chk_seq("R5 keep pos", 8'd3, 2, 9, 2);
    nlog = 0;
    cmd(3'd3, 8'd0, 32'd30, 32'd0, 8'h00);
    cmd(3'd3, 8'd0, 32'hFFFF_FFFF, 32'd1, 8'h01);
    ticks(2);
    chk_seq("R5 reposition", 8'd3, 1, 31, 0);
  endtask

  task automatic t_ms();
    cmd(3'd0, 8'd1, 32'h0000_0005, 0, 0);
    cmd(3'd1, 8'd1, 32'h0000_0100, 0, 0);
    cmd(3'd2, 8'd1, 32'd8, 0, 0);
    nlog = 0;
    cmd(3'd3, 8'd1, 32'd100, 32'd375, 8'h02);
    ticks(5);
    chk_seq("R7 375ms", 8'd0, 3, 100, 1);
    nlog = 0;
    cmd(3'd3, 8'd1, 32'd100, 32'd374, 8'h02);
    ticks(5);
    chk_seq("R7 374ms", 8'd0, 2, 100, 1);
  endtask

  task automatic t_end();
    cmd(3'd6, 8'd0, 32'd0, 32'd40, 0);
    cmd(3'd6, 8'd1, 32'd40, 32'd8, 0);
    nlog = 0;
    cmd(3'd3, 8'd1, 32'd45, 32'd0, 8'h03);
    ticks(6);
    chk_seq("R8 to end", 8'd0, 3, 45, 1);
    nlog = 0;
    cmd(3'd3, 8'd1, 32'd2, 32'd0, 8'h13);
    ticks(6);
    chk_seq("R8 R9 reverse to zero", 8'd0, 3, 2, -1);
    nlog = 0;
    cmd(3'd3, 8'd1, 32'd50, 32'd3, 8'h11);
    ticks(5);
    chk_seq("R9 reverse count", 8'd0, 3, 50, -1);
  endtask

  task automatic t_loop();
    cmd(3'd2, 8'd0, 32'd8, 0, 0);
    nlog = 0;
    cmd(3'd3, 8'd0, 32'd10, 32'd2, 8'h81);
    ticks(7);
    chk("R10 loop count", 32'(nlog), 5);
    chk_at("R10 w0", 0, 8'd3, 11);
    chk_at("R10 w1", 1, 8'd3, 13);
    chk_at("R10 w2 restart", 2, 8'd3, 11);
    chk_at("R10 w3", 3, 8'd3, 13);
    chk_at("R10 w4", 4, 8'd3, 11);
    cmd(3'd5, 8'd0, 0, 0, 0);
    nlog = 0;
    ticks(3);
    chk("R11 stop one", 32'(nlog), 0);
  endtask

  task automatic t_stop();
    cmd(3'd3, 8'd0, 32'd0, 32'd0, 8'h03);
    cmd(3'd3, 8'd1, 32'd0, 32'd0, 8'h03);
    ticks(2);
    cmd(3'd5, 8'd5, 0, 0, 0);
    nlog = 0;
    ticks(2);
    chk("R11 unknown id ignored", 32'(nlog), 4);
    cmd(3'd5, 8'd1, 0, 0, 0);
    nlog = 0;
    ticks(2);
    chk("R11 stream1 stopped", 32'(nlog), 2);
    chk("R11 survivor chip", 32'(lc[1]), 32'h82);
    cmd(3'd5, 8'hFF, 0, 0, 0);
    nlog = 0;
    ticks(3);
    chk("R11 stop all", 32'(nlog), 0);
  endtask

  task automatic t_fast();
    cmd(3'd6, 8'd2, 32'd64, 32'd8, 0);
    nlog = 0;
    cmd(3'd4, 8'd0, 32'd2, 0, 8'h00);
    ticks(6);
    chk_seq("R12 fast fwd", 8'd3, 4, 65, 2);
    nlog = 0;
    cmd(3'd4, 8'd0, 32'd2, 0, 8'h10);
    ticks(6);
    chk_seq("R12 fast rev", 8'd3, 4, 71, -2);
    nlog = 0;
    cmd(3'd4, 8'd0, 32'd2, 0, 8'h01);
    ticks(6);
    chk("R12 fast loop count", 32'(nlog), 5);
    chk_at("R12 fast loop restart", 4, 8'd3, 65);
    cmd(3'd5, 8'd0, 0, 0, 0);
  endtask

  task automatic t_prio();
    cmd(3'd3, 8'd0, 32'd0, 32'd1, 8'h01);
    cmd(3'd3, 8'd1, 32'd7, 32'd1, 8'h01);
    nlog = 0;
    ticks(2);
    chk("R13 both served", 32'(nlog), 2);
    chk("R13 low index first", 32'(lc[0]), 32'h82);
    chk("R13 then stream1", 32'(lc[1]), 32'h05);
    chk_at("R13 data s0", 0, 8'd3, 1);
    chk_at("R13 data s1", 1, 8'd0, 7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_keep();
    t_ms();
    t_end();
    t_loop();
    t_stop();
    t_fast();
    t_prio();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule